// File: doc/BRIEF.md
# Boot Configuration Word Capture

This block keeps a device core in reset until an external host has loaded a 32-bit boot configuration word over a byte-wide register write path. The host issues single-cycle write strobes. Each strobe carries an address and a data byte. Four fixed addresses each hold one byte of the word, from least to most significant. The block records which of the four bytes have arrived. When all four are present, it raises a clock-lock request and waits for the lock to be confirmed. It then releases the core reset and freezes the captured word.

The write path is a plain strobe and has no back-pressure. A strobe is taken in the cycle it is seen, so no ready signal exists. The host may write the bytes in any order. It may also rewrite a byte while reset is still held. A hard reset input, active low and asynchronous, returns the block to its held state at any time.

Top module: `boot_cfg_capture`

## Requirements
- R1: A write to address 0x8 loads cfg_word[7:0], 0x9 loads [15:8], 0xA loads [23:16] and 0xB loads [31:24]. The new value is visible on cfg_word in the cycle after the write strobe is sampled.
- R2: A write to any address outside 0x8 to 0xB changes no byte of cfg_word and does not count toward the four-byte set.
- R3: core_rst_n stays 0 until each of the four byte addresses has been written at least once. The order of the writes does not matter.
- R4: Before release, a rewrite of a byte that is already written replaces its value. It is not counted as a further byte.
- R5: lock_req goes to 1 one cycle after the write that completes the four-byte set. It stays 1 until lock_done is sampled high, and it is 0 at all other times.
- R6: lock_done sampled high while lock_req is 1 makes core_rst_n go to 1 two cycles later. lock_done has no effect while the byte set is incomplete.
- R7: Once core_rst_n is 1, it stays 1 and cfg_word stays frozen. Writes to the configuration addresses are ignored.
- R8: por_n low clears cfg_word to 0, clears the record of written bytes, drives core_rst_n to 0 and drives lock_req to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Hard/power-on reset, asynchronous, active low |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data byte |
| lock_done | input | 1 | Clock lock confirmation |
| lock_req | output | 1 | Request to lock clocks |
| cfg_word | output | 32 | Assembled configuration word |
| core_rst_n | output | 1 | Core reset, active low; 1 means released |

## Verification
The bench writes the bytes in reverse and mixed order. A design that counted writes instead of tracking lanes would release too early in the rewrite test, or would put bytes in the wrong lanes. Strobes to neighbouring addresses 0x7 and 0xC must leave the word at zero and keep lock_req low, which catches a decoder that is off by one in its range. The bench holds lock_done high while the byte set is still incomplete, checks the exact cycles of lock_req and core_rst_n, and writes after release. These catch a release that comes early or late and a word that is not frozen. A hard reset in the middle of the lock phase must clear everything.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_LOCK    = 2'd1,
    ST_SETTLE  = 2'd2,
    ST_RUN     = 2'd3
  } rel_state_e;
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 8,
  parameter int NBYTES   = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NBYTES-1:0] lane_sel
);
  // One compare per byte lane; at most one lane matches a given address.
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign lane_sel[i] = wr_en && (wr_addr == ADDR_W'(BASE_OFF + i));
  end
endmodule

// File: rtl/cfg_byte_store.sv
module cfg_byte_store #(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              accept,
  input  logic [NBYTES-1:0] lane_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [WORD_W-1:0] word,
  output logic [NBYTES-1:0] mask
);
  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        lane_q  <= '0;
        mask[i] <= 1'b0;
      end else if (accept && lane_sel[i]) begin
        lane_q  <= wr_data;
        mask[i] <= 1'b1;
      end
    end
    assign word[i*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/cfg_release_fsm.sv
module cfg_release_fsm
  import boot_cfg_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic mask_full,
  input  logic lock_done,
  output logic accept,
  output logic lock_req,
  output logic core_rst_n
);
  rel_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: if (mask_full) state_d = ST_LOCK;
      ST_LOCK:    if (lock_done) state_d = ST_SETTLE;
      ST_SETTLE:  state_d = ST_RUN;
      ST_RUN:     state_d = ST_RUN;
      default:    state_d = ST_COLLECT;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) state_q <= ST_COLLECT;
    else        state_q <= state_d;
  end

  assign accept     = (state_q != ST_RUN);
  assign lock_req   = (state_q == ST_LOCK);
  assign core_rst_n = (state_q == ST_RUN);
endmodule

// File: rtl/boot_cfg_capture.sv
module boot_cfg_capture #(
  parameter int ADDR_W   = 4,
  parameter int BASE_OFF = 8,
  parameter int NBYTES   = 4,
  parameter int BYTE_W   = 8,
  localparam int WORD_W  = NBYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              lock_done,
  output logic              lock_req,
  output logic [WORD_W-1:0] cfg_word,
  output logic              core_rst_n
);
  logic [NBYTES-1:0] lane_sel;
  logic [NBYTES-1:0] byte_mask;
  logic              accept;

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF), .NBYTES(NBYTES)
  ) dec_i (
    .wr_en(wr_en), .wr_addr(wr_addr), .lane_sel(lane_sel)
  );

  cfg_byte_store #(
    .NBYTES(NBYTES), .BYTE_W(BYTE_W)
  ) store_i (
    .clk(clk), .por_n(por_n), .accept(accept), .lane_sel(lane_sel),
    .wr_data(wr_data), .word(cfg_word), .mask(byte_mask)
  );

  cfg_release_fsm fsm_i (
    .clk(clk), .por_n(por_n), .mask_full(&byte_mask), .lock_done(lock_done),
    .accept(accept), .lock_req(lock_req), .core_rst_n(core_rst_n)
  );
endmodule

// File: rtl/boot_cfg_capture_chk.sv
module boot_cfg_capture_chk #(
  parameter int NBYTES = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = NBYTES * BYTE_W
) (
  input logic              clk,
  input logic              por_n,
  input logic              lock_req,
  input logic              lock_done,
  input logic              core_rst_n,
  input logic [WORD_W-1:0] cfg_word,
  input logic [NBYTES-1:0] byte_mask
);
  AST_HOLD_UNTIL_FULL: assert property (@(posedge clk) disable iff (!por_n)
    !(&byte_mask) |-> !core_rst_n); // R3
  AST_REQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!por_n)
    lock_req |-> (&byte_mask)); // R5
  AST_RELEASE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!por_n)
    $rose(core_rst_n) |-> ($past(lock_done, 2) && $past(lock_req, 2))); // R6
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    core_rst_n |=> core_rst_n); // R7
  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    core_rst_n |=> $stable(cfg_word)); // R7
  AST_NO_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!por_n)
    core_rst_n |-> !lock_req); // R5
endmodule

bind boot_cfg_capture boot_cfg_capture_chk #(
  .NBYTES(NBYTES), .BYTE_W(BYTE_W)
) chk_i (
  .clk(clk), .por_n(por_n), .lock_req(lock_req), .lock_done(lock_done),
  .core_rst_n(core_rst_n), .cfg_word(cfg_word), .byte_mask(byte_mask)
);

// File: tb/boot_cfg_capture_tb_top.sv
module boot_cfg_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        lock_done = 1'b0;
  logic        lock_req;
  logic [31:0] cfg_word;
  logic        core_rst_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_cfg_capture dut_i (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lock_done(lock_done), .lock_req(lock_req),
    .cfg_word(cfg_word), .core_rst_n(core_rst_n)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    por_n = 1'b0; wr_en = 1'b0; lock_done = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    @(negedge clk);
  endtask

  // Strobe for one cycle; returns at the negedge after capture.
  task automatic host_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Completes lock handshake from the LOCK phase; checks R6 timing.
  task automatic finish_lock();
    lock_done = 1'b1;
    @(negedge clk);
    lock_done = 1'b0;
    check("R6 still held one cycle after lock_done", {31'd0, core_rst_n}, 32'd0);
    check("R5 lock_req drops after lock_done", {31'd0, lock_req}, 32'd0);
    @(negedge clk);
    check("R6 released two cycles after lock_done", {31'd0, core_rst_n}, 32'd1);
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R8 word cleared", cfg_word, 32'h0);
    check("R8 core held", {31'd0, core_rst_n}, 32'd0);
    check("R8 no lock_req", {31'd0, lock_req}, 32'd0);
  endtask

  task automatic t_in_order();
    do_reset();
    host_write(4'h8, 8'h11);
    check("R1 lane0 at 0x8", cfg_word, 32'h0000_0011);
    host_write(4'h9, 8'h22);
    host_write(4'hA, 8'h33);
    check("R3 held with three bytes", {31'd0, core_rst_n}, 32'd0);
    host_write(4'hB, 8'h44);
    check("R1 assembled word", cfg_word, 32'h4433_2211);
    check("R5 no lock_req in completing cycle", {31'd0, lock_req}, 32'd0);
    @(negedge clk);
    check("R5 lock_req raised", {31'd0, lock_req}, 32'd1);
    idle(3);
    check("R5 lock_req held while waiting", {31'd0, lock_req}, 32'd1);
    check("R6 held while waiting lock", {31'd0, core_rst_n}, 32'd0);
    finish_lock();
  endtask

  task automatic t_out_of_order();
    do_reset();
    host_write(4'hB, 8'hDE);
    host_write(4'h8, 8'hEF);
    host_write(4'hA, 8'hAD);
    check("R3 held before last byte", {31'd0, core_rst_n}, 32'd0);
    host_write(4'h9, 8'hBE);
    check("R1 mixed order word", cfg_word, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R3 lock_req after mixed order", {31'd0, lock_req}, 32'd1);
    finish_lock();
  endtask

  task automatic t_stray_and_early_lock();
    do_reset();
    lock_done = 1'b1;
    host_write(4'h7, 8'hFF);
    host_write(4'hC, 8'hFF);
    host_write(4'h0, 8'hFF);
    host_write(4'hF, 8'hFF);
    idle(2);
    check("R2 stray writes leave word", cfg_word, 32'h0);
    check("R2 stray writes no lock_req", {31'd0, lock_req}, 32'd0);
    check("R6 lock_done ignored while incomplete", {31'd0, core_rst_n}, 32'd0);
    lock_done = 1'b0;
  endtask

  task automatic t_rewrite_and_freeze();
    do_reset();
    host_write(4'h8, 8'h01);
    host_write(4'h9, 8'h02);
    host_write(4'h8, 8'hA5);
    host_write(4'hA, 8'h03);
    idle(3);
    check("R4 rewrite replaces value", cfg_word, 32'h0003_02A5);
    check("R4 rewrite not counted", {31'd0, lock_req}, 32'd0);
    host_write(4'hB, 8'h04);
    @(negedge clk);
    check("R4 lock_req after fourth distinct", {31'd0, lock_req}, 32'd1);
    host_write(4'h9, 8'h77);
    check("R4 rewrite during lock phase", cfg_word, 32'h0403_77A5);
    finish_lock();
    host_write(4'h8, 8'hFF);
    host_write(4'hB, 8'hEE);
    idle(2);
    check("R7 word frozen after release", cfg_word, 32'h0403_77A5);
    check("R7 stays released", {31'd0, core_rst_n}, 32'd1);
    check("R7 no lock_req after release", {31'd0, lock_req}, 32'd0);
  endtask

  task automatic t_por_midway();
    do_reset();
    host_write(4'h8, 8'h10);
    host_write(4'h9, 8'h20);
    host_write(4'hA, 8'h30);
    host_write(4'hB, 8'h40);
    @(negedge clk);
    check("R8 precondition lock_req", {31'd0, lock_req}, 32'd1);
    #1 por_n = 1'b0;
    #1;
    check("R8 async clear word", cfg_word, 32'h0);
    check("R8 async clear lock_req", {31'd0, lock_req}, 32'd0);
    check("R8 async hold core", {31'd0, core_rst_n}, 32'd0);
    @(negedge clk);
    por_n = 1'b1;
    host_write(4'h8, 8'h55);
    idle(2);
    check("R8 mask cleared by reset", {31'd0, lock_req}, 32'd0);
  endtask

  initial begin
    t_reset_state();
    t_in_order();
    t_out_of_order();
    t_stray_and_early_lock();
    t_rewrite_and_freeze();
    t_por_midway();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule